// File: doc/BRIEF.md
# Dual-Modulus Fractional Clock Divider

This block turns a 10 MHz reference clock into a 32.768 kHz clock with no frequency error. A fixed integer divide cannot hit that ratio, so the block alternates between two neighbouring divide values. Each output period lasts either `BASE_DIV` input clocks (short) or `BASE_DIV + 1` input clocks (long). A small controller spreads the long periods as evenly as it can across each frame of output periods. With the default parameters, every 256 consecutive output periods cover exactly 78125 input clocks. That is 10e6/32768 exactly.

The controller is a look-ahead error accumulator that steps by `LONG_PERIODS`, modulo `FRAME_PERIODS`. A period is long exactly when the step taken at its end will wrap the accumulator. The divided clock and a one-clock period strobe both pass through the same two-stage retiming pipeline, so they stay aligned. An enable input freezes the divider without losing its phase.

Top module: `frac_clk_div`

## Requirements
- R1: While `rst_n` is low, `div_clk_o` and `period_stb_o` are 0. After reset is released, the first output period is short (`BASE_DIV` = 305 clocks), and period numbering restarts at 0.
- R2: With `enable` held high, every output period, measured from one `period_stb_o` pulse to the next, lasts 305 or 306 input clocks.
- R3: Take the periods after reset in consecutive groups of 256, starting at period 0. Each group spans exactly 78125 input clocks.
- R4: Each such group of 256 periods contains exactly 45 long (306-clock) periods.
- R5: Period p (counted from 0 after reset) is long exactly when floor(45·(p+1)/256) > floor(45·p/256). This holds even when the last clock of a period is stalled by `enable`. As a consequence, no two long periods are adjacent.
- R6: In each period of modulus M, `div_clk_o` is high for the first floor(M/2) input clocks and low for the rest.
- R7: `period_stb_o` is high for exactly one input clock per period. That clock is the first clock of the period, in which `div_clk_o` is high.
- R8: While `enable` is low, the divider state holds. After two retiming clocks, `div_clk_o` keeps its level and `period_stb_o` stays 0. The period containing the stall is longer by exactly the number of stalled clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input reference clock (10 MHz in the target use) |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Advances the divider when high; freezes it when low |
| div_clk_o | output | 1 | Retimed divided clock |
| period_stb_o | output | 1 | One-clock pulse at the start of each output period |

## Verification
The end of a period, where the prescaler wraps, is also the moment the modulus controller advances. A stall from `enable` can land on that same clock. The bench provokes this by dropping `enable` exactly while the prescaler sits on its last count. It holds `enable` low for 20 clocks, with the outputs checked each clock to be low and strobe-free. It then judges two things: the stalled period must measure its modulus plus 20, and the following period must still have the length the placement formula predicts. That shows the controller stepped exactly once. A second stall in the middle of a high phase, and a full two-frame run, cover the remaining behaviour.

// File: rtl/frac_div_pkg.sv
// Package: default division constants shared by the divider modules.
// Assumes LONG_PERIODS <= FRAME_PERIODS / 2, so long periods never run back to back.
package frac_div_pkg;
    localparam int DEF_BASE_DIV      = 305;  // short period length in input clocks
    localparam int DEF_LONG_PERIODS  = 45;   // long periods per frame
    localparam int DEF_FRAME_PERIODS = 256;  // output periods per frame
    localparam int DEF_RETIME_STAGES = 2;    // retiming flops on the outputs
endpackage

// File: rtl/fdiv_prescaler.sv
// Prescaler: counts input clocks modulo BASE_DIV or BASE_DIV+1, as chosen by long_sel.
// It flags the first and last count of each period and produces the raw divided clock,
// which is high for the first floor(M/2) counts of a period.
// Assumes long_sel changes only on a clock where wrap_o is high.
module fdiv_prescaler #(
    parameter int BASE_DIV = 305,
    parameter int CNT_W    = $clog2(BASE_DIV + 2)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic long_sel,
    output logic wrap_o,
    output logic start_o,
    output logic clk_raw_o
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_cnt;
    logic [CNT_W-1:0] half_cnt;

    // Last count and high-phase length for the current modulus.
    always_comb begin
        last_cnt = CNT_W'(BASE_DIV - 1) + CNT_W'(long_sel);
        half_cnt = (CNT_W'(BASE_DIV) + CNT_W'(long_sel)) >> 1;
    end

    // Period counter: advances while enabled and wraps at the last count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (en)
            cnt <= (cnt == last_cnt) ? '0 : cnt + 1'b1;
    end

    assign wrap_o    = en && (cnt == last_cnt);
    assign start_o   = en && (cnt == '0);
    assign clk_raw_o = (cnt < half_cnt);

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last_cnt); // R2
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(cnt)); // R8
endmodule

// File: rtl/fdiv_modctl.sv
// Modulus controller: a look-ahead error accumulator that steps by LONG_PERIODS,
// modulo FRAME_PERIODS, once per prescaler wrap. The current period is long when
// the coming step will overflow, so FRAME_PERIODS periods hold exactly LONG_PERIODS long ones.
// Assumes wrap is a single-clock pulse at the last count of a period.
module fdiv_modctl #(
    parameter int LONG_PERIODS  = 45,
    parameter int FRAME_PERIODS = 256,
    parameter int ACC_W         = $clog2(FRAME_PERIODS),
    parameter int SUM_W         = ACC_W + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    output logic long_sel_o
);
    logic [ACC_W-1:0] acc;
    logic [SUM_W-1:0] sum;
    logic             overflow;
    logic [SUM_W-1:0] acc_next;

    // Next accumulator value and its overflow, which marks the current period as long.
    always_comb begin
        sum      = {1'b0, acc} + SUM_W'(LONG_PERIODS);
        overflow = (sum >= SUM_W'(FRAME_PERIODS));
        acc_next = overflow ? (sum - SUM_W'(FRAME_PERIODS)) : sum;
    end

    // Error accumulator: steps once per completed output period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (wrap)
            acc <= acc_next[ACC_W-1:0];
    end

    assign long_sel_o = overflow;

    AST_MOD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(long_sel_o)); // R2
    AST_NO_DOUBLE_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && long_sel_o) |=> !long_sel_o); // R5
endmodule

// File: rtl/fdiv_retime.sv
// Retimer: a STAGES-deep register pipeline that cleans up the combinational outputs.
// All bits are delayed by the same amount, so they stay aligned. It clears on reset
// and shifts on every clock, whatever the enable.
module fdiv_retime #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // One retiming stage.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pipe[s] <= '0;
            else if (s == 0)
                pipe[s] <= d;
            else
                pipe[s] <= pipe[(s == 0) ? 0 : s - 1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/frac_clk_div.sv
// Top: dual-modulus fractional clock divider. The prescaler divides by BASE_DIV or
// BASE_DIV+1, the controller picks the modulus per period, and the retimer registers
// the divided clock and the period strobe.
// Assumes a free-running input clock and a synchronous, active-low reset.
module frac_clk_div
    import frac_div_pkg::*;
#(
    parameter int BASE_DIV      = DEF_BASE_DIV,
    parameter int LONG_PERIODS  = DEF_LONG_PERIODS,
    parameter int FRAME_PERIODS = DEF_FRAME_PERIODS,
    parameter int RETIME_STAGES = DEF_RETIME_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic div_clk_o,
    output logic period_stb_o
);
    localparam int CNT_W = $clog2(BASE_DIV + 2);
    localparam int ACC_W = $clog2(FRAME_PERIODS);

    logic       long_sel;
    logic       wrap;
    logic       start;
    logic       clk_raw;
    logic [1:0] retimed;

    fdiv_prescaler #(.BASE_DIV(BASE_DIV), .CNT_W(CNT_W)) u_prescaler (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (enable),
        .long_sel (long_sel),
        .wrap_o   (wrap),
        .start_o  (start),
        .clk_raw_o(clk_raw)
    );

    fdiv_modctl #(
        .LONG_PERIODS (LONG_PERIODS),
        .FRAME_PERIODS(FRAME_PERIODS),
        .ACC_W        (ACC_W)
    ) u_modctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wrap      (wrap),
        .long_sel_o(long_sel)
    );

    fdiv_retime #(.WIDTH(2), .STAGES(RETIME_STAGES)) u_retime (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({start, clk_raw}),
        .q    (retimed)
    );

    assign period_stb_o = retimed[1];
    assign div_clk_o    = retimed[0];

    AST_STROBE_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        period_stb_o |-> div_clk_o); // R7
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        period_stb_o |=> !period_stb_o); // R7
endmodule

// File: tb/frac_clk_div_tb.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module frac_clk_div_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b1;
    logic div_clk_o;
    logic period_stb_o;

    int n_chk = 0;
    int n_fail = 0;
    int p_idx = 0;   // period number since the last reset

    always #2.5 clk = ~clk;

    frac_clk_div u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .div_clk_o   (div_clk_o),
        .period_stb_o(period_stb_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int is_long(input int p);
        return (((45 * (p + 1)) / 256) != ((45 * p) / 256)) ? 1 : 0;
    endfunction

    // Measures one period, starting at a negedge where the strobe is seen. An optional stall is inserted.
    task automatic run_period(input int stall_at, input int stall_len, input bit lvl,
                              output int len, output int hi);
        len = 0;
        hi = 0;
        forever begin
            if (div_clk_o) hi++;
            if (len == stall_at && stall_len > 0) begin
                enable = 1'b0;
                for (int k = 0; k < stall_len; k++) begin
                    @(negedge clk);
                    len++;
                    if (k >= 2) begin
                        check(div_clk_o == lvl, "R8 level held", div_clk_o, lvl);
                        check(period_stb_o == 1'b0, "R8 no strobe", period_stb_o, 0);
                    end
                end
                enable = 1'b1;
            end
            @(negedge clk);
            len++;
            if (period_stb_o) break;
        end
    endtask

    task automatic wait_first_strobe();
        int guard = 0;
        while (!period_stb_o && guard < 10) begin
            @(negedge clk);
            guard++;
        end
        check(period_stb_o == 1'b1, "R7 strobe after reset", period_stb_o, 1);
        check(div_clk_o == 1'b1, "R7 high at strobe", div_clk_o, 1);
        p_idx = 0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        check(div_clk_o == 1'b0, "R1 clk low in reset", div_clk_o, 0);
        check(period_stb_o == 1'b0, "R1 strobe low in reset", period_stb_o, 0);
        rst_n = 1'b1;
        wait_first_strobe();
    endtask

    task automatic t_frames(input int frames);
        int len, hi, m, sum, longs;
        for (int f = 0; f < frames; f++) begin
            sum = 0;
            longs = 0;
            for (int i = 0; i < 256; i++) begin
                m = 305 + is_long(p_idx);
                run_period(-1, 0, 1'b0, len, hi);
                if (p_idx == 0) check(len == 305, "R1 first period short", len, 305);
                check(len == 305 || len == 306, "R2 period length", len, m);
                check(len == m, "R5 long placement", len, m);
                check(hi == m / 2, "R6 high time", hi, m / 2);
                sum += len;
                longs += (len == 306) ? 1 : 0;
                p_idx++;
            end
            check(sum == 78125, "R3 frame clocks", sum, 78125);
            check(longs == 45, "R4 long count", longs, 45);
        end
    endtask

    task automatic t_enable();
        int len, hi, m;
        m = 305 + is_long(p_idx);
        run_period(100, 40, 1'b1, len, hi);
        check(len == m + 40, "R8 mid-high stall", len, m + 40);
        p_idx++;
        m = 305 + is_long(p_idx);
        run_period(m - 3, 20, 1'b0, len, hi);
        check(len == m + 20, "R8 stall on last count", len, m + 20);
        p_idx++;
        m = 305 + is_long(p_idx);
        run_period(-1, 0, 1'b0, len, hi);
        check(len == m, "R5 after coincident stall", len, m);
        p_idx++;
    endtask

    task automatic t_reset_mid();
        int len, hi;
        repeat (50) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(div_clk_o == 1'b0, "R1 clk cleared", div_clk_o, 0);
        check(period_stb_o == 1'b0, "R1 strobe cleared", period_stb_o, 0);
        rst_n = 1'b1;
        wait_first_strobe();
        run_period(-1, 0, 1'b0, len, hi);
        check(len == 305, "R1 restart short", len, 305);
        p_idx = 1;
        run_period(-1, 0, 1'b0, len, hi);
        check(len == 305 + is_long(1), "R5 restart second", len, 305 + is_long(1));
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_frames(2);
        t_enable();
        t_reset_mid();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (199000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule